// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors signal each other through per-channel "occupied" flags. Each processor has its own small register bank on a shared 32-bit read/write bus. To send on channel n, a processor raises its own flag for that channel. The other processor sees the flag, takes the message from memory outside this block, and then lowers that flag to acknowledge it. Only the owner can raise a flag, and only the peer can lower it.

Each processor has two interrupt lines. The receive line fires when the peer holds an unmasked channel occupied. The transmit line fires when one of the processor's own unmasked channels is free. Each line also has its own enable bit. The channel count can be set from 1 to 16. Two read-only words report that count and a revision number.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After reset, all flags are clear. Both control words read 0. Every mask bit of a used channel reads 1. All four interrupt outputs are low.
- R2: Bank p sits at byte offset 0x10*p and holds four words. The control word is at +0x0. Its bit 0 is the receive enable and its bit 16 is the transmit enable. These two bits read back as written, and all other bits read 0.
- R3: The mask word is at +0x4. Bit n masks channel n's receive interrupt and bit 16+n masks its transmit interrupt (1 = masked). The mask word reads back as written.
- R4: The command word is at +0x8. Writing 1 to bit 16+n of bank p sets processor p's flag for channel n. Zero bits change nothing. The command word always reads 0. The status word at +0xC returns processor p's own flags in bits n.
- R5: Writing 1 to bit n of bank p's command word clears the peer processor's flag for channel n. It leaves processor p's own flags unchanged.
- R6: irq_rx[p] is high exactly when the receive enable of p is set and some channel has the peer's flag set with p's receive mask bit clear.
- R7: irq_tx[p] is high exactly when the transmit enable of p is set and some channel has p's own flag clear with p's transmit mask bit clear.
- R8: Byte address 0x3F0 returns the channel count in bits 7:0. Address 0x3F4 returns the minor revision in bits 3:0 and the major revision in bits 7:4. Writes to both addresses are ignored.
- R9: Channels at or above the configured count ignore every write. Their bits read 0 in the mask and status words, and they never raise an interrupt.
- R10: Addresses outside the two banks and the two identity words read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, 0 when not reading |
| irq_rx | output | 2 | Receive interrupt per processor |
| irq_tx | output | 2 | Transmit interrupt per processor |

## Verification
The bench targets the asymmetry between the two processors.

- A command word sent to the wrong bank would raise or lower the wrong processor's flag. The status readback after every random write exposes this.
- A transmit interrupt built on the occupied flag instead of the free flag would fire while the channel is busy and stay silent once it is free.
- A receive interrupt that looked at the processor's own flags would not follow the peer's sends.
- Under a 12-channel configuration, writes to channels 12 to 15 must leave no trace. A design that stored them would show extra status or mask bits, or stray interrupts.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_MASK   = 2'd1,
      REG_CMD    = 2'd2,
      REG_STATUS = 2'd3
   } mbox_reg_e;

   localparam int MBOX_PROCS   = 2;
   localparam int TX_SHIFT     = 16;
   localparam int CTRL_RX_BIT  = 0;
   localparam int CTRL_TX_BIT  = 16;
   localparam logic [9:0] ADDR_HWCFG = 10'h3F0;
   localparam logic [9:0] ADDR_VER   = 10'h3F4;
endpackage

// File: rtl/mbox_bank.sv
module mbox_bank #(
   parameter int NCH = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_ctrl,
   input  logic           wr_mask,
   input  logic [31:0]    wdata,
   output logic           rx_en,
   output logic           tx_en,
   output logic [NCH-1:0] mask_rx,
   output logic [NCH-1:0] mask_tx
);
   import mbox_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_en   <= 1'b0;
         tx_en   <= 1'b0;
         mask_rx <= '1;
         mask_tx <= '1;
      end else begin
         if (wr_ctrl) begin
            rx_en <= wdata[CTRL_RX_BIT];
            tx_en <= wdata[CTRL_TX_BIT];
         end
         if (wr_mask) begin
            mask_rx <= wdata[NCH-1:0];
            mask_tx <= wdata[TX_SHIFT +: NCH];
         end
      end
   end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
   parameter int NCH   = 16,
   parameter int PROCS = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [PROCS-1:0][NCH-1:0] set_req,
   input  logic [PROCS-1:0][NCH-1:0] clr_req,
   output logic [PROCS-1:0][NCH-1:0] occ
);
   // a set arriving with a clear leaves the flag raised
   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else begin
         for (int p = 0; p < PROCS; p++)
            occ[p] <= (occ[p] & ~clr_req[p]) | set_req[p];
      end
   end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
   parameter int NCH     = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rx_en,
   input  logic           tx_en,
   input  logic [NCH-1:0] mask_rx,
   input  logic [NCH-1:0] mask_tx,
   input  logic [NCH-1:0] own_occ,
   input  logic [NCH-1:0] peer_occ,
   output logic           irq_rx,
   output logic           irq_tx
);
   logic rx_next, tx_next;

   assign rx_next = rx_en & |(peer_occ & ~mask_rx);
   assign tx_next = tx_en & |(~own_occ & ~mask_tx);

   generate
      if (REG_OUT) begin : g_flop
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               irq_rx <= 1'b0;
               irq_tx <= 1'b0;
            end else begin
               irq_rx <= rx_next;
               irq_tx <= tx_next;
            end
         end
      end else begin : g_comb
         assign irq_rx = rx_next;
         assign irq_tx = tx_next;
      end
   endgenerate
endmodule

// File: rtl/mbox_flag_ctrl.sv
module mbox_flag_ctrl #(
   parameter int         NUM_CH    = 16,
   parameter int         ADDR_W    = 10,
   parameter logic [3:0] VER_MAJOR = 4'd1,
   parameter logic [3:0] VER_MINOR = 4'd0,
   parameter bit         REG_IRQ   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [1:0]        irq_rx,
   output logic [1:0]        irq_tx
);
   import mbox_pkg::*;

   localparam int NP = MBOX_PROCS;

   generate
      if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_nch
         $error("NUM_CH must lie in 1..16");
      end
      if (ADDR_W < 10) begin : g_bad_aw
         $error("ADDR_W must be at least 10");
      end
   endgenerate

   logic                       bank_hit, bank_id, wr_any, rd_any;
   mbox_reg_e                  reg_sel;
   logic [ADDR_W-1:0]          word_addr;
   logic [NP-1:0]              wr_ctrl, wr_mask, wr_cmd;
   logic [NP-1:0]              rx_en, tx_en;
   logic [NP-1:0][NUM_CH-1:0]  mask_rx, mask_tx;
   logic [NP-1:0][NUM_CH-1:0]  set_req, clr_req;
   logic [NP-1:0][NUM_CH-1:0]  occ;

   assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
   assign bank_hit  = (bus_addr[ADDR_W-1:5] == '0);
   assign bank_id   = bus_addr[4];
   assign reg_sel   = mbox_reg_e'(bus_addr[3:2]);
   assign wr_any    = bus_sel & bus_wr;
   assign rd_any    = bus_sel & ~bus_wr;

   generate
      for (genvar p = 0; p < NP; p++) begin : g_proc
         logic hit_p;
         assign hit_p      = wr_any & bank_hit & (bank_id == 1'(p));
         assign wr_ctrl[p] = hit_p & (reg_sel == REG_CTRL);
         assign wr_mask[p] = hit_p & (reg_sel == REG_MASK);
         assign wr_cmd[p]  = hit_p & (reg_sel == REG_CMD);
         assign set_req[p] = wr_cmd[p] ? bus_wdata[TX_SHIFT +: NUM_CH] : '0;
         assign clr_req[p] = wr_cmd[NP-1-p] ? bus_wdata[NUM_CH-1:0] : '0;

         mbox_bank #(.NCH(NUM_CH)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_ctrl[p]),
            .wr_mask (wr_mask[p]),
            .wdata   (bus_wdata),
            .rx_en   (rx_en[p]),
            .tx_en   (tx_en[p]),
            .mask_rx (mask_rx[p]),
            .mask_tx (mask_tx[p])
         );

         mbox_irq #(.NCH(NUM_CH), .REG_OUT(REG_IRQ)) u_irq (
            .clk      (clk),
            .rst_n    (rst_n),
            .rx_en    (rx_en[p]),
            .tx_en    (tx_en[p]),
            .mask_rx  (mask_rx[p]),
            .mask_tx  (mask_tx[p]),
            .own_occ  (occ[p]),
            .peer_occ (occ[NP-1-p]),
            .irq_rx   (irq_rx[p]),
            .irq_tx   (irq_tx[p])
         );
      end
   endgenerate

   mbox_flags #(.NCH(NUM_CH), .PROCS(NP)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_req),
      .clr_req (clr_req),
      .occ     (occ)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd_any) begin
         if (bank_hit) begin
            unique case (reg_sel)
               REG_CTRL: begin
                  bus_rdata[CTRL_RX_BIT] = rx_en[bank_id];
                  bus_rdata[CTRL_TX_BIT] = tx_en[bank_id];
               end
               REG_MASK: begin
                  bus_rdata[NUM_CH-1:0]          = mask_rx[bank_id];
                  bus_rdata[TX_SHIFT +: NUM_CH]  = mask_tx[bank_id];
               end
               REG_STATUS: bus_rdata[NUM_CH-1:0] = occ[bank_id];
               default: bus_rdata = '0;
            endcase
         end else if (word_addr == ADDR_W'(ADDR_HWCFG)) begin
            bus_rdata[7:0] = 8'(NUM_CH);
         end else if (word_addr == ADDR_W'(ADDR_VER)) begin
            bus_rdata[7:0] = {VER_MAJOR, VER_MINOR};
         end
      end
   end
endmodule

// File: rtl/mbox_flag_chk.sv
module mbox_flag_chk #(
   parameter int NCH     = 16,
   parameter int ADDR_W  = 10,
   parameter bit REG_IRQ = 1'b0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_sel,
   input logic                  bus_wr,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [31:0]           bus_wdata,
   input logic [1:0]            irq_rx,
   input logic [1:0]            irq_tx,
   input logic [1:0][NCH-1:0]   occ
);
   logic cmd_wr;
   assign cmd_wr = bus_sel && bus_wr && (bus_addr[ADDR_W-1:5] == '0) && (bus_addr[3:2] == 2'd2);

   // R4
   occ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> $stable(occ));

   generate
      for (genvar p = 0; p < 2; p++) begin : g_p
         for (genvar n = 0; n < NCH; n++) begin : g_n
            // R4
            occ_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
               cmd_wr && (bus_addr[4] == 1'(p)) && bus_wdata[16+n] |=> occ[p][n]);
            // R5
            occ_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
               cmd_wr && (bus_addr[4] != 1'(p)) && bus_wdata[n] |=> !occ[p][n]);
         end
         if (!REG_IRQ) begin : g_comb
            // R6
            rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (occ[1-p] == '0) |-> !irq_rx[p]);
            // R7
            tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (occ[p] == '1) |-> !irq_tx[p]);
         end
      end
   endgenerate
endmodule

bind mbox_flag_ctrl mbox_flag_chk #(.NCH(NUM_CH), .ADDR_W(ADDR_W), .REG_IRQ(REG_IRQ)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_rx    (irq_rx),
   .irq_tx    (irq_tx),
   .occ       (occ)
);

// File: tb/mbox_flag_ctrl_tb.sv
`timescale 1ns/1ps
module mbox_flag_ctrl_tb;
   localparam int NCH = 12;
   localparam int AW  = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [1:0]    irq_rx, irq_tx;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [NCH-1:0] m_occ [2];
   logic [NCH-1:0] m_mrx [2];
   logic [NCH-1:0] m_mtx [2];
   logic           m_rxen [2];
   logic           m_txen [2];

   always #10 clk = ~clk;

   mbox_flag_ctrl #(.NUM_CH(NCH), .ADDR_W(AW), .VER_MAJOR(4'd2), .VER_MINOR(4'd5)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_rx(irq_rx), .irq_tx(irq_tx));

   function automatic void model_reset();
      for (int b = 0; b < 2; b++) begin
         m_occ[b] = '0; m_mrx[b] = '1; m_mtx[b] = '1; m_rxen[b] = 0; m_txen[b] = 0;
      end
   endfunction

   function automatic void model_write(logic [AW-1:0] a, logic [31:0] d);
      int b;
      if (a[AW-1:5] != 0) return;
      b = a[4];
      case (a[3:2])
         2'd0: begin m_rxen[b] = d[0]; m_txen[b] = d[16]; end
         2'd1: begin m_mrx[b] = d[NCH-1:0]; m_mtx[b] = d[16 +: NCH]; end
         2'd2: begin
            m_occ[b]   = m_occ[b] | d[16 +: NCH];
            m_occ[1-b] = m_occ[1-b] & ~d[NCH-1:0];
         end
         default: ;
      endcase
   endfunction

   function automatic logic [31:0] model_read(logic [AW-1:0] a);
      logic [31:0] r = '0;
      int b;
      if (a[AW-1:5] == 0) begin
         b = a[4];
         case (a[3:2])
            2'd0: begin r[0] = m_rxen[b]; r[16] = m_txen[b]; end
            2'd1: begin r[NCH-1:0] = m_mrx[b]; r[16 +: NCH] = m_mtx[b]; end
            2'd3: r[NCH-1:0] = m_occ[b];
            default: r = '0;
         endcase
      end else if ({a[AW-1:2], 2'b00} == 10'h3F0) r = NCH;
      else if ({a[AW-1:2], 2'b00} == 10'h3F4) r = 32'h25;
      return r;
   endfunction

   function automatic logic [3:0] model_irq();
      logic [3:0] v;
      for (int p = 0; p < 2; p++) begin
         v[p]   = m_rxen[p] & |(m_occ[1-p] & ~m_mrx[p]);
         v[2+p] = m_txen[p] & |(~m_occ[p] & ~m_mtx[p]);
      end
      return v;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      model_write(a, d);
   endtask

   task automatic rd(logic [AW-1:0] a, string tag);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1;
      chk(tag, bus_rdata, model_read(a));
      bus_sel = 0;
   endtask

   task automatic irq_chk(string tag);
      chk(tag, {28'd0, irq_tx, irq_rx}, {28'd0, model_irq()});
   endtask

   initial begin
      logic [AW-1:0] a;
      logic [31:0]   d;
      void'($urandom(32'h5EED_0042));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      for (int r = 0; r < 8; r++) rd(AW'(r * 4), "R1 reset read");
      chk("R1 reset irq", {28'd0, irq_tx, irq_rx}, 32'd0);
      // R8 identity words, writes ignored
      wr(10'h3F0, 32'hFFFF_FFFF); wr(10'h3F4, 32'h0);
      rd(10'h3F0, "R8 hwcfg"); rd(10'h3F4, "R8 version");
      chk("R8 hwcfg value", model_read(10'h3F0), 32'd12);
      // R2 control readback
      wr(10'h000, 32'hFFFF_FFFF); rd(10'h000, "R2 ctrl bank0");
      wr(10'h010, 32'h0001_0000); rd(10'h010, "R2 ctrl bank1");
      // R3 mask readback, R9 unused mask bits read 0
      wr(10'h004, 32'hFFFF_FFFF); rd(10'h004, "R3 R9 mask full");
      wr(10'h014, 32'h0A5A_0C3C); rd(10'h014, "R3 mask pattern");
      // R9 unused channel set ignored
      wr(10'h008, 32'hF000_0000); rd(10'h00C, "R9 unused set");
      chk("R9 status zero", model_read(10'h00C), 32'd0);
      // R4 set own flag, cmd reads 0
      wr(10'h004, 32'h0000_0000);
      wr(10'h018, 32'h0008_0000); rd(10'h01C, "R4 set ch3 bank1");
      rd(10'h018, "R4 cmd reads zero");
      irq_chk("R6 R7 rx after peer set");
      chk("R6 rx0 high", {31'd0, irq_rx[0]}, 32'd1);
      // R5 ack clears peer only
      wr(10'h008, 32'h0001_0008); rd(10'h01C, "R5 peer cleared");
      rd(10'h00C, "R5 own set kept");
      irq_chk("R6 R7 after ack");
      chk("R7 tx0 ch0 busy but others free", {31'd0, irq_tx[0]}, 32'd1);
      // R10 unmapped
      wr(10'h040, 32'hFFFF_FFFF); rd(10'h040, "R10 unmapped");
      rd(10'h000, "R10 bank0 ctrl untouched");
      // random traffic
      for (int i = 0; i < 400; i++) begin
         case ($urandom_range(0, 9))
            0: a = 10'h3F0;
            1: a = AW'($urandom_range(8, 40) * 4);
            default: a = AW'($urandom_range(0, 7) * 4);
         endcase
         d = $urandom();
         if ($urandom_range(0, 2) == 0) d = d & 32'h000F_000F;
         wr(a, d);
         irq_chk("R6 R7 random irq");
         a = AW'($urandom_range(0, 7) * 4);
         case (a[3:2])
            2'd0: rd(a, "R2 random ctrl");
            2'd1: rd(a, "R3 random mask");
            2'd2: rd(a, "R4 random cmd");
            default: rd(a, "R4 R5 random status");
         endcase
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule